// File: doc/BRIEF.md
# Command Packet Register Decoder

This block sits behind a command-word fetcher and turns a stream of 32-bit command words into register write transactions. Each packet opens with a header word whose two top bits pick one of four formats: a burst of writes to consecutive registers, a pair of writes to two unrelated registers, a filler word with no payload, or an opaque opcode whose payload words are passed on unchanged for another unit to execute.

Words enter on a valid/ready port. Register writes leave on an index/data/strobe port with its own ready, and opcode payload leaves on a separate port that marks the first and last word of each packet. Outputs pass through combinationally from the input word. A stall on either output therefore drops the input ready in the same cycle. A synchronous abort discards any partial packet, and a flag reports header words whose unused bits are not zero.

Top module: `pkt_reg_decoder`

## Requirements
- R1: Bits 31:30 of a word taken while a header is expected select the packet kind: 00 register burst, 01 register pair, 10 filler, 11 opcode. The header itself produces no register write and no opcode word.
- R2: For a burst header, bits 29:16 give N and bits 10:0 give a start register index. The next N+1 words are each issued with `reg_we_o` high and `reg_data_o` equal to the word. The first word goes to the start index, and the index rises by one for each following word.
- R3: The burst index is 11 bits wide. It carries across any bit boundary (0x3FF to 0x400) and wraps from 0x7FF to 0x000.
- R4: For a pair header, exactly two words follow. The first is written to the index in bits 10:0 and the second to the index in bits 21:11.
- R5: A filler header is taken in one cycle with no output, and the word after it is decoded as a header.
- R6: For an opcode header, bits 15:8 give the opcode and bits 29:16 give N. The next N+1 words appear on `op_valid_o`/`op_data_o` with `op_code_o` equal to the opcode. `op_first_o` is high only on the first of these words and `op_last_o` only on the last. No register write is issued.
- R7: During a payload, `word_ready_o` follows the ready of the output port in use. While that ready is low, the output stays asserted with an unchanged index or flags, and no word is lost or repeated.
- R8: While a header is expected, `word_ready_o` is high whatever the output readies are, and `reg_we_o` and `op_valid_o` are low.
- R9: In a cycle with `abort_i` high, no word is taken and no output is asserted. In the next cycle the decoder expects a header.
- R10: `hdr_err_o` is high in the cycle a malformed header is taken. A header is malformed if it is a burst with bits 15:11 not zero, a pair with bits 29:22 not zero, a filler with bits 29:0 not zero, or an opcode with bits 7:0 not zero. The packet is still decoded by its kind.
- R11: After reset the decoder expects a header, `word_ready_o` is high, and `reg_we_o`, `op_valid_o` and `hdr_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| abort_i | input | 1 | Synchronous abort of the current packet |
| word_valid_i | input | 1 | Input word valid |
| word_data_i | input | 32 | Input command word |
| word_ready_o | output | 1 | Input word taken when high with valid |
| reg_we_o | output | 1 | Register write strobe |
| reg_idx_o | output | 11 | Register dword index |
| reg_data_o | output | 32 | Register write data |
| reg_ready_i | input | 1 | Register port can accept a write |
| op_valid_o | output | 1 | Opcode payload word valid |
| op_code_o | output | 8 | Opcode of the current packet |
| op_data_o | output | 32 | Opcode payload word |
| op_first_o | output | 1 | First payload word of the opcode packet |
| op_last_o | output | 1 | Last payload word of the opcode packet |
| op_ready_i | input | 1 | Opcode port can accept a word |
| hdr_err_o | output | 1 | Malformed header taken this cycle |

## Verification
The bench builds the decoder with `STRICT_HDR` at 1. This setting enables the malformed-header checks, so a corrupted header of each of the four kinds can be shown to raise the flag while its packet still decodes normally. The 11-bit index width lets bursts that start at 0x3FE and 0x7FF reach both the carry into bit 10 and the wrap to zero within a few words. Small count fields keep every packet kind, back to back, inside one short table. Directed runs add stalls in the middle of a payload and an abort in the middle of a packet.

// File: rtl/pkt_dec_pkg.sv
package pkt_dec_pkg;
  localparam int WORD_W = 32;
  localparam int IDX_W  = 11;
  localparam int CNT_W  = 14;
  localparam int OPC_W  = 8;

  typedef enum logic [1:0] {
    PKT_BURST = 2'b00,
    PKT_PAIR  = 2'b01,
    PKT_FILL  = 2'b10,
    PKT_OPC   = 2'b11
  } pkt_kind_e;

  typedef struct packed {
    pkt_kind_e        kind;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] idx_a;
    logic [IDX_W-1:0] idx_b;
    logic [OPC_W-1:0] opc;
    logic             bad;
  } hdr_t;

  typedef enum logic [2:0] {
    ST_HDR, ST_BURST, ST_PAIR_A, ST_PAIR_B, ST_OPC
  } seq_st_e;
endpackage

// File: rtl/pkt_hdr_split.sv
module pkt_hdr_split
  import pkt_dec_pkg::*;
#(
  parameter bit STRICT = 1'b1
) (
  input  logic [WORD_W-1:0] word_i,
  output hdr_t              hdr_o
);
  logic bad_w;

  generate
    if (STRICT) begin : g_strict
      always_comb begin
        unique case (word_i[31:30])
          2'b00:   bad_w = |word_i[15:11];
          2'b01:   bad_w = |word_i[29:22];
          2'b10:   bad_w = |word_i[29:0];
          default: bad_w = |word_i[7:0];
        endcase
      end
    end else begin : g_loose
      assign bad_w = 1'b0;
    end
  endgenerate

  always_comb begin
    hdr_o.kind  = pkt_kind_e'(word_i[31:30]);
    hdr_o.cnt   = word_i[29:16];
    hdr_o.idx_a = word_i[10:0];
    hdr_o.idx_b = word_i[21:11];
    hdr_o.opc   = word_i[15:8];
    hdr_o.bad   = bad_w;
  end
endmodule

// File: rtl/pkt_seq.sv
module pkt_seq
  import pkt_dec_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             abort_i,
  input  hdr_t             hdr_i,
  input  logic             in_valid_i,
  input  logic             reg_ready_i,
  input  logic             op_ready_i,
  output logic             in_ready_o,
  output logic             reg_we_o,
  output logic [IDX_W-1:0] reg_idx_o,
  output logic             op_valid_o,
  output logic [OPC_W-1:0] op_code_o,
  output logic             op_first_o,
  output logic             op_last_o,
  output logic             hdr_err_o
);
  seq_st_e          st_q;
  logic [CNT_W-1:0] rem_q;
  logic [IDX_W-1:0] idx_q, idx_b_q;
  logic [OPC_W-1:0] opc_q;
  logic             first_q;
  logic             fire, last_w;

  assign last_w = (rem_q == '0);

  always_comb begin
    in_ready_o = 1'b0;
    reg_we_o   = 1'b0;
    op_valid_o = 1'b0;
    hdr_err_o  = 1'b0;
    if (!abort_i) begin
      unique case (st_q)
        ST_HDR: begin
          in_ready_o = 1'b1;
          hdr_err_o  = in_valid_i & hdr_i.bad;
        end
        ST_BURST, ST_PAIR_A, ST_PAIR_B: begin
          in_ready_o = reg_ready_i;
          reg_we_o   = in_valid_i;
        end
        ST_OPC: begin
          in_ready_o = op_ready_i;
          op_valid_o = in_valid_i;
        end
        default: ;
      endcase
    end
  end

  assign fire       = in_valid_i & in_ready_o;
  assign reg_idx_o  = idx_q;
  assign op_code_o  = opc_q;
  assign op_first_o = op_valid_o & first_q;
  assign op_last_o  = op_valid_o & last_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_HDR;
      rem_q   <= '0;
      idx_q   <= '0;
      idx_b_q <= '0;
      opc_q   <= '0;
      first_q <= 1'b0;
    end else if (abort_i) begin
      st_q <= ST_HDR;
    end else if (fire) begin
      unique case (st_q)
        ST_HDR: begin
          unique case (hdr_i.kind)
            PKT_BURST: begin
              rem_q <= hdr_i.cnt;
              idx_q <= hdr_i.idx_a;
              st_q  <= ST_BURST;
            end
            PKT_PAIR: begin
              idx_q   <= hdr_i.idx_a;
              idx_b_q <= hdr_i.idx_b;
              st_q    <= ST_PAIR_A;
            end
            PKT_OPC: begin
              rem_q   <= hdr_i.cnt;
              opc_q   <= hdr_i.opc;
              first_q <= 1'b1;
              st_q    <= ST_OPC;
            end
            default: ;
          endcase
        end
        ST_BURST: begin
          idx_q <= idx_q + 1'b1;
          if (last_w) st_q <= ST_HDR;
          else        rem_q <= rem_q - 1'b1;
        end
        ST_PAIR_A: begin
          idx_q <= idx_b_q;
          st_q  <= ST_PAIR_B;
        end
        ST_PAIR_B: st_q <= ST_HDR;
        ST_OPC: begin
          first_q <= 1'b0;
          if (last_w) st_q <= ST_HDR;
          else        rem_q <= rem_q - 1'b1;
        end
        default: st_q <= ST_HDR;
      endcase
    end
  end

  AST_HDR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_HDR |-> !reg_we_o && !op_valid_o); // R8
  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BURST && fire && !last_w) |=>
      st_q == ST_BURST && idx_q == IDX_W'($past(idx_q) + 1'b1)); // R2
  AST_PAIR_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PAIR_A && fire) |=> st_q == ST_PAIR_B && idx_q == $past(idx_b_q)); // R4
  AST_FILL_STAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HDR && fire && hdr_i.kind == PKT_FILL) |=> st_q == ST_HDR); // R5
  AST_FIRST_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && in_ready_o) |=> !op_first_o); // R6
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_HDR && in_valid_i && !in_ready_o && !abort_i) |=>
      $stable(st_q) && $stable(idx_q) && $stable(rem_q) && $stable(first_q)); // R7
  AST_ABORT_HDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> st_q == ST_HDR); // R9
endmodule

// File: rtl/pkt_reg_decoder.sv
module pkt_reg_decoder
  import pkt_dec_pkg::*;
#(
  parameter bit STRICT_HDR = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_data_i,
  output logic              word_ready_o,
  output logic              reg_we_o,
  output logic [IDX_W-1:0]  reg_idx_o,
  output logic [WORD_W-1:0] reg_data_o,
  input  logic              reg_ready_i,
  output logic              op_valid_o,
  output logic [OPC_W-1:0]  op_code_o,
  output logic [WORD_W-1:0] op_data_o,
  output logic              op_first_o,
  output logic              op_last_o,
  input  logic              op_ready_i,
  output logic              hdr_err_o
);
  hdr_t hdr_w;

  pkt_hdr_split #(.STRICT(STRICT_HDR)) u_split (
    .word_i (word_data_i),
    .hdr_o  (hdr_w)
  );

  pkt_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .abort_i     (abort_i),
    .hdr_i       (hdr_w),
    .in_valid_i  (word_valid_i),
    .reg_ready_i (reg_ready_i),
    .op_ready_i  (op_ready_i),
    .in_ready_o  (word_ready_o),
    .reg_we_o    (reg_we_o),
    .reg_idx_o   (reg_idx_o),
    .op_valid_o  (op_valid_o),
    .op_code_o   (op_code_o),
    .op_first_o  (op_first_o),
    .op_last_o   (op_last_o),
    .hdr_err_o   (hdr_err_o)
  );

  assign reg_data_o = word_data_i;
  assign op_data_o  = word_data_i;

  AST_REG_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && !reg_ready_i) |-> !word_ready_o); // R7
  AST_OP_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && !op_ready_i) |-> !word_ready_o); // R7
  AST_ONE_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |-> !reg_we_o); // R6
endmodule

// File: tb/tb_pkt_reg_decoder.sv
`timescale 1ns/1ps
module tb_pkt_reg_decoder;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        abort_i = 1'b0;
  logic        word_valid_i = 1'b0;
  logic [31:0] word_data_i = '0;
  logic        reg_ready_i = 1'b1;
  logic        op_ready_i = 1'b1;
  logic        word_ready_o, reg_we_o, op_valid_o, op_first_o, op_last_o, hdr_err_o;
  logic [10:0] reg_idx_o;
  logic [31:0] reg_data_o, op_data_o;
  logic [7:0]  op_code_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pkt_reg_decoder #(.STRICT_HDR(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .abort_i(abort_i),
    .word_valid_i(word_valid_i), .word_data_i(word_data_i), .word_ready_o(word_ready_o),
    .reg_we_o(reg_we_o), .reg_idx_o(reg_idx_o), .reg_data_o(reg_data_o), .reg_ready_i(reg_ready_i),
    .op_valid_o(op_valid_o), .op_code_o(op_code_o), .op_data_o(op_data_o),
    .op_first_o(op_first_o), .op_last_o(op_last_o), .op_ready_i(op_ready_i),
    .hdr_err_o(hdr_err_o)
  );

  // k: 0 none, 1 register write, 2 opcode word
  typedef struct packed {
    logic [31:0] w;
    logic [1:0]  k;
    logic [10:0] idx;
    logic [7:0]  opc;
    logic        f;
    logic        l;
    logic        e;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{32'h000200FE, 2'd0, 11'h000, 8'h00, 1'b0, 1'b0, 1'b0}, // R1 burst hdr
    '{32'h000000A0, 2'd1, 11'h0FE, 8'h00, 1'b0, 1'b0, 1'b0}, // R2
    '{32'h000000A1, 2'd1, 11'h0FF, 8'h00, 1'b0, 1'b0, 1'b0}, // R2
    '{32'h000000A2, 2'd1, 11'h100, 8'h00, 1'b0, 1'b0, 1'b0}, // R3 carry
    '{32'h40091810, 2'd0, 11'h000, 8'h00, 1'b0, 1'b0, 1'b0}, // R1 pair hdr
    '{32'h000000B0, 2'd1, 11'h010, 8'h00, 1'b0, 1'b0, 1'b0}, // R4
    '{32'h000000B1, 2'd1, 11'h123, 8'h00, 1'b0, 1'b0, 1'b0}, // R4
    '{32'h80000000, 2'd0, 11'h000, 8'h00, 1'b0, 1'b0, 1'b0}, // R5 filler
    '{32'hC0019B00, 2'd0, 11'h000, 8'h00, 1'b0, 1'b0, 1'b0}, // R1 opcode hdr
    '{32'h000000C0, 2'd2, 11'h000, 8'h9B, 1'b1, 1'b0, 1'b0}, // R6
    '{32'h000000C1, 2'd2, 11'h000, 8'h9B, 1'b0, 1'b1, 1'b0}, // R6
    '{32'h000007FF, 2'd0, 11'h000, 8'h00, 1'b0, 1'b0, 1'b0}, // R1
    '{32'h000000D0, 2'd1, 11'h7FF, 8'h00, 1'b0, 1'b0, 1'b0}, // R2 single word
    '{32'hC0002300, 2'd0, 11'h000, 8'h00, 1'b0, 1'b0, 1'b0}, // R1
    '{32'h000000E0, 2'd2, 11'h000, 8'h23, 1'b1, 1'b1, 1'b0}, // R6 first and last
    '{32'h80000005, 2'd0, 11'h000, 8'h00, 1'b0, 1'b0, 1'b1}, // R10 filler
    '{32'h000107FF, 2'd0, 11'h000, 8'h00, 1'b0, 1'b0, 1'b0}, // R1
    '{32'h000000F0, 2'd1, 11'h7FF, 8'h00, 1'b0, 1'b0, 1'b0}, // R3
    '{32'h000000F1, 2'd1, 11'h000, 8'h00, 1'b0, 1'b0, 1'b0}, // R3 wrap
    '{32'h40403005, 2'd0, 11'h000, 8'h00, 1'b0, 1'b0, 1'b1}, // R10 pair
    '{32'h00000011, 2'd1, 11'h005, 8'h00, 1'b0, 1'b0, 1'b0}, // R10 still decoded
    '{32'h00000012, 2'd1, 11'h006, 8'h00, 1'b0, 1'b0, 1'b0}, // R4
    '{32'h00000801, 2'd0, 11'h000, 8'h00, 1'b0, 1'b0, 1'b1}, // R10 burst
    '{32'h00000033, 2'd1, 11'h001, 8'h00, 1'b0, 1'b0, 1'b0}, // R10
    '{32'hC0009A01, 2'd0, 11'h000, 8'h00, 1'b0, 1'b0, 1'b1}, // R10 opcode
    '{32'h00000044, 2'd2, 11'h000, 8'h9A, 1'b1, 1'b1, 1'b0}  // R6
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic put(input logic [31:0] w);
    @(negedge clk);
    word_valid_i = 1'b1;
    word_data_i  = w;
    #1;
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.e)       return "R10";
    if (v.k == 2)  return "R6";
    if (v.k == 1)  return "R2";
    return "R1";
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog R11 actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    // R11 reset state
    chk("R11", {60'd0, word_ready_o, reg_we_o, op_valid_o, hdr_err_o}, {60'd0, 4'b1000});
    rst_ni = 1'b1;

    // table walk, all readies high
    for (int i = 0; i < NV; i++) begin
      put(VECS[i].w);
      chk(tag_of(VECS[i]),
          {38'd0, reg_we_o, op_valid_o, (VECS[i].k == 2'd1) ? reg_idx_o : 11'h0,
           (VECS[i].k == 2'd2) ? op_code_o : 8'h0, op_first_o, op_last_o, hdr_err_o, word_ready_o},
          {38'd0, VECS[i].k == 2'd1, VECS[i].k == 2'd2, VECS[i].idx, VECS[i].opc,
           VECS[i].f, VECS[i].l, VECS[i].e, 1'b1});
      if (VECS[i].k == 2'd1) chk("R2", {32'd0, reg_data_o}, {32'd0, VECS[i].w});
      if (VECS[i].k == 2'd2) chk("R6", {32'd0, op_data_o}, {32'd0, VECS[i].w});
    end

    // R8: header taken even when both output ports are stalled
    @(negedge clk);
    reg_ready_i = 1'b0;
    op_ready_i  = 1'b0;
    word_valid_i = 1'b1;
    word_data_i  = 32'h000203FE;
    #1;
    chk("R8", {62'd0, word_ready_o, reg_we_o}, {62'd0, 2'b10});
    reg_ready_i = 1'b1;
    op_ready_i  = 1'b1;

    // R7 stall inside a burst, R3 carry after the stall
    put(32'h1);
    chk("R2", {53'd0, reg_we_o, reg_idx_o}, {53'd0, 1'b1, 11'h3FE});
    @(negedge clk);
    reg_ready_i = 1'b0;
    word_data_i = 32'h2;
    #1;
    for (int s = 0; s < 3; s++) begin
      chk("R7", {51'd0, word_ready_o, reg_we_o, reg_idx_o}, {51'd0, 2'b01, 11'h3FF});
      @(negedge clk);
      #1;
    end
    reg_ready_i = 1'b1;
    #1;
    chk("R7", {51'd0, word_ready_o, reg_we_o, reg_idx_o}, {51'd0, 2'b11, 11'h3FF});
    put(32'h3);
    chk("R3", {53'd0, reg_we_o, reg_idx_o}, {53'd0, 1'b1, 11'h400});

    // R7 stall inside an opcode payload
    put(32'hC0029400);
    put(32'h10);
    chk("R6", {52'd0, op_valid_o, op_first_o, op_last_o, op_code_o, word_ready_o},
              {52'd0, 3'b110, 8'h94, 1'b1});
    @(negedge clk);
    op_ready_i  = 1'b0;
    word_data_i = 32'h11;
    #1;
    for (int s = 0; s < 2; s++) begin
      chk("R7", {60'd0, op_valid_o, op_first_o, op_last_o, word_ready_o}, {60'd0, 4'b1000});
      @(negedge clk);
      #1;
    end
    op_ready_i = 1'b1;
    #1;
    chk("R7", {32'd0, op_data_o}, {32'd0, 32'h11});
    put(32'h12);
    chk("R6", {61'd0, op_valid_o, op_first_o, op_last_o}, {61'd0, 3'b101});

    // R9 abort in the middle of an opcode packet
    put(32'hC0059A00);
    put(32'h20);
    @(negedge clk);
    abort_i     = 1'b1;
    word_data_i = 32'h21;
    #1;
    chk("R9", {61'd0, word_ready_o, op_valid_o, reg_we_o}, {61'd0, 3'b000});
    @(negedge clk);
    abort_i     = 1'b0;
    word_data_i = 32'h00000020;
    #1;
    chk("R9", {61'd0, word_ready_o, op_valid_o, reg_we_o}, {61'd0, 3'b100});
    put(32'h55);
    chk("R9", {53'd0, reg_we_o, reg_idx_o}, {53'd0, 1'b1, 11'h020});

    // idle input while a header is expected
    @(negedge clk);
    word_valid_i = 1'b0;
    #1;
    chk("R8", {61'd0, reg_we_o, op_valid_o, hdr_err_o}, {61'd0, 3'b000});

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule